// File: doc/BRIEF.md
# USB Bulk IN Endpoint Handshake and Status Controller

This block holds the control and status state of one bulk IN endpoint of a USB device. It sits between a synchronous CPU register and a simplified packet engine. The engine reports each IN token, the host's ACK or a response timeout, and any point where the transmit FIFO runs dry in the middle of a packet. For every token the block answers with a handshake choice: send data with the current DATA0/DATA1 PID, NAK, or STALL. It also drives a one-cycle FIFO flush strobe and a CRC-corrupt strobe to the engine. Serial encoding, the CRC generator and the FIFO storage sit outside it.

Software sees one status/control word. Four status flags are write-one-to-clear. One bit forces the endpoint into the halted condition and can be read back. The data toggle is visible as a read-only bit. Halting an endpoint in the middle of a transaction takes effect only once that transaction has finished. The endpoint stays halted until software has dropped both the force bit and the sent-stall flag. The set-force, clear-force, clear-sent-stall sequence that ends a halt also returns the toggle to DATA0.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset every register bit reads 0 (toggle at DATA0) and no handshake is issued.
- R2: A token that arrives while no transaction is open, the stall state is off, force is clear, data is ready and done (bit 0) is clear is answered in the next cycle with hs_code 2'b01 (send data) and hs_pid equal to the toggle (read bit 5). This opens a transaction.
- R3: A token with force clear and stall off, when either done is set or pkt_ready is low, is answered with hs_code 2'b10 (NAK). No transaction opens.
- R4: A host_ack during an open transaction closes it, sets done and flips the toggle, unless that packet had an underrun.
- R5: A host_timeout without host_ack during an open transaction closes it, sets done and err (bit 1) and leaves the toggle unchanged. err is never set while done is clear.
- R6: fifo_underrun during an open transaction sets urun (bit 2) and raises crc_corrupt in the next cycle. An ACK of that packet does not flip the toggle.
- R7: Writing 1 to bit 0 clears done, err and urun. Writing 1 to bit 1 or bit 2 clears only that flag. A hardware set in the same cycle as a clear wins.
- R8: Bit 4 (force) takes the written value on every write. While force or the stall state is on, an idle token is answered with hs_code 2'b11 (STALL), and each STALL sets sstl (bit 3).
- R9: Force set during an open transaction enters the stall state, and sets sstl, only after the transaction has closed.
- R10: Writing 1 to bit 3 while sstl is set clears it and pulses fifo_flush for one cycle. The pulse does not occur if a set of sstl wins in the same cycle.
- R11: The stall state ends only in a cycle where force and sstl both read 0. Leaving it returns the toggle to DATA0.
- R12: A token that arrives while a transaction is open gets no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data: bits 0 done, 1 err, 2 urun, 3 sstl, 4 force, 5 toggle |
| in_token | input | 1 | One-cycle strobe: an IN token arrived |
| pkt_ready | input | 1 | A full packet is loaded in the FIFO |
| host_ack | input | 1 | Host ACK for the open transaction |
| host_timeout | input | 1 | No handshake from the host for the open transaction |
| fifo_underrun | input | 1 | FIFO ran empty inside the open packet |
| hs_valid | output | 1 | A handshake decision is presented this cycle |
| hs_code | output | 2 | 01 send data, 10 NAK, 11 STALL |
| hs_pid | output | 1 | Data PID for a send: 0 DATA0, 1 DATA1 |
| fifo_flush | output | 1 | One-cycle FIFO flush strobe |
| crc_corrupt | output | 1 | Corrupt the CRC of the packet in flight |

## Verification
The bound checker watches several invariants on every cycle. err never stands without done. No handshake follows a cycle with an open transaction, and a send always opens one. A STALL only follows force or the stall state. Stall entry only follows an idle cycle, and stall exit lands with both bits clear and the toggle at DATA0. A flush only accompanies an actual clear of sstl, and an underrun always brings the CRC-corrupt strobe. The exact handshake choice, the PID carried by each packet, toggle history across ACK, timeout and underrun, and the full halt-and-recover sequence can only be shown by the bench's scenarios, which compare every cycle against a requirement-level model.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
   // handshake decision codes presented with hs_valid
   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_DATA  = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_e;

   // register bit positions; the four flags occupy the low bits in this order
   localparam int B_DONE  = 0;
   localparam int B_ERR   = 1;
   localparam int B_URUN  = 2;
   localparam int B_SSTL  = 3;
   localparam int B_FORCE = 4;
   localparam int B_TOG   = 5;
   localparam int N_FLAGS = 4;
   localparam int MIN_REG_W = 6;
   // flags also cleared when done is cleared
   localparam logic [N_FLAGS-1:0] FOLLOW_DONE = 4'b0110;
endpackage

// File: rtl/ep_flag.sv
module ep_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/ep_csr.sv
module ep_csr
   import usb_in_ep_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [REG_W-1:0]    wdata,
   input  logic [N_FLAGS-1:0]  flag_set,
   input  logic                toggle,
   output logic [REG_W-1:0]    rdata,
   output logic [N_FLAGS-1:0]  flags,
   output logic                force_stall,
   output logic                flush
);
   logic [N_FLAGS-1:0] flag_clr;
   logic               unused_wbits;

   assign unused_wbits = ^wdata[REG_W-1:B_TOG];

   for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      assign flag_clr[i] = we & (wdata[i] | (FOLLOW_DONE[i] & wdata[B_DONE]));
      ep_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (flag_set[i]),
         .clr   (flag_clr[i]),
         .q     (flags[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_stall <= 1'b0;
         flush       <= 1'b0;
      end else begin
         if (we) force_stall <= wdata[B_FORCE];
         flush <= flag_clr[B_SSTL] & flags[B_SSTL] & ~flag_set[B_SSTL];
      end
   end

   always_comb begin
      rdata              = '0;
      rdata[N_FLAGS-1:0] = flags;
      rdata[B_FORCE]     = force_stall;
      rdata[B_TOG]       = toggle;
   end
endmodule

// File: rtl/ep_stall.sv
module ep_stall (
   input  logic clk,
   input  logic rst_n,
   input  logic force_stall,
   input  logic sstl,
   input  logic busy,
   output logic in_stall,
   output logic enter,
   output logic leave
);
   assign enter = force_stall & ~busy & ~in_stall;
   assign leave = in_stall & ~force_stall & ~sstl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_stall <= 1'b0;
      else if (enter) in_stall <= 1'b1;
      else if (leave) in_stall <= 1'b0;
   end
endmodule

// File: rtl/ep_txn.sv
module ep_txn
   import usb_in_ep_pkg::*;
#(
   parameter int CORRUPT_HOLD = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       token,
   input  logic       pkt_ready,
   input  logic       done,
   input  logic       stall_now,
   input  logic       host_ack,
   input  logic       host_timeout,
   input  logic       fifo_underrun,
   input  logic       toggle_clr,
   output logic       hs_valid,
   output logic [1:0] hs_code,
   output logic       hs_pid,
   output logic       busy,
   output logic       done_set,
   output logic       err_set,
   output logic       urun_set,
   output logic       stall_hs,
   output logic       crc_corrupt,
   output logic       toggle
);
   logic accept, send, fin, bad, bad_now;

   assign accept   = token & ~busy;
   assign stall_hs = accept & stall_now;
   assign send     = accept & ~stall_now & pkt_ready & ~done;
   assign fin      = busy & (host_ack | host_timeout);
   assign done_set = fin;
   assign err_set  = busy & host_timeout & ~host_ack;
   assign urun_set = busy & fifo_underrun;
   assign bad_now  = bad | urun_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_valid <= 1'b0;
         hs_code  <= HS_NONE;
         hs_pid   <= 1'b0;
         busy     <= 1'b0;
         bad      <= 1'b0;
         toggle   <= 1'b0;
      end else begin
         hs_valid <= accept;
         if (stall_hs)    hs_code <= HS_STALL;
         else if (send)   hs_code <= HS_DATA;
         else if (accept) hs_code <= HS_NAK;
         else             hs_code <= HS_NONE;
         hs_pid <= send & toggle;
         if (send)     busy <= 1'b1;
         else if (fin) busy <= 1'b0;
         if (send)          bad <= 1'b0;
         else if (urun_set) bad <= 1'b1;
         if (toggle_clr)                       toggle <= 1'b0;
         else if (fin & host_ack & ~bad_now)   toggle <= ~toggle;
      end
   end

   if (CORRUPT_HOLD == 0) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) crc_corrupt <= 1'b0;
         else        crc_corrupt <= urun_set;
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) crc_corrupt <= 1'b0;
         else        crc_corrupt <= urun_set | (crc_corrupt & busy & ~fin);
      end
   end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
   import usb_in_ep_pkg::*;
#(
   parameter int REG_W        = 8,
   parameter int CORRUPT_HOLD = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             in_token,
   input  logic             pkt_ready,
   input  logic             host_ack,
   input  logic             host_timeout,
   input  logic             fifo_underrun,
   output logic             hs_valid,
   output logic [1:0]       hs_code,
   output logic             hs_pid,
   output logic             fifo_flush,
   output logic             crc_corrupt
);
   if (REG_W < MIN_REG_W) begin : g_bad_width
      $error("usb_in_ep_ctrl: REG_W below minimum");
   end
   if (CORRUPT_HOLD != 0 && CORRUPT_HOLD != 1) begin : g_bad_hold
      $error("usb_in_ep_ctrl: CORRUPT_HOLD must be 0 or 1");
   end

   logic [N_FLAGS-1:0] flags, flag_set;
   logic force_stall, toggle, busy, in_stall, enter, leave;
   logic done_set, err_set, urun_set, stall_hs, stall_now;

   assign stall_now = force_stall | in_stall;

   always_comb begin
      flag_set         = '0;
      flag_set[B_DONE] = done_set;
      flag_set[B_ERR]  = err_set;
      flag_set[B_URUN] = urun_set;
      flag_set[B_SSTL] = enter | stall_hs;
   end

   ep_csr #(.REG_W(REG_W)) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (reg_we),
      .wdata       (reg_wdata),
      .flag_set    (flag_set),
      .toggle      (toggle),
      .rdata       (reg_rdata),
      .flags       (flags),
      .force_stall (force_stall),
      .flush       (fifo_flush)
   );

   ep_stall u_stall (
      .clk         (clk),
      .rst_n       (rst_n),
      .force_stall (force_stall),
      .sstl        (flags[B_SSTL]),
      .busy        (busy),
      .in_stall    (in_stall),
      .enter       (enter),
      .leave       (leave)
   );

   ep_txn #(.CORRUPT_HOLD(CORRUPT_HOLD)) u_txn (
      .clk           (clk),
      .rst_n         (rst_n),
      .token         (in_token),
      .pkt_ready     (pkt_ready),
      .done          (flags[B_DONE]),
      .stall_now     (stall_now),
      .host_ack      (host_ack),
      .host_timeout  (host_timeout),
      .fifo_underrun (fifo_underrun),
      .toggle_clr    (leave),
      .hs_valid      (hs_valid),
      .hs_code       (hs_code),
      .hs_pid        (hs_pid),
      .busy          (busy),
      .done_set      (done_set),
      .err_set       (err_set),
      .urun_set      (urun_set),
      .stall_hs      (stall_hs),
      .crc_corrupt   (crc_corrupt),
      .toggle        (toggle)
   );
endmodule

// File: rtl/usb_in_ep_chk.sv
module usb_in_ep_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hs_valid,
   input logic [1:0] hs_code,
   input logic       fifo_flush,
   input logic       crc_corrupt,
   input logic       busy,
   input logic       in_stall,
   input logic       force_stall,
   input logic [3:0] flags,
   input logic       toggle
);
   assert_data_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'b01) |-> busy);

   assert_err_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flags[1] |-> flags[0]);

   assert_crc_on_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[2]) |-> crc_corrupt);

   assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'b11) |-> $past(force_stall || in_stall));

   assert_entry_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_stall) |-> (flags[3] && !$past(busy)));

   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> (!flags[3] && $past(flags[3])));

   assert_exit_both_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_stall) |-> (!toggle && !$past(force_stall) && !$past(flags[3])));

   assert_quiet_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> !$past(busy));
endmodule

bind usb_in_ep_ctrl usb_in_ep_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hs_valid    (hs_valid),
   .hs_code     (hs_code),
   .fifo_flush  (fifo_flush),
   .crc_corrupt (crc_corrupt),
   .busy        (busy),
   .in_stall    (in_stall),
   .force_stall (force_stall),
   .flags       (flags),
   .toggle      (toggle)
);

// File: tb/usb_in_ep_ctrl_tb.sv
module usb_in_ep_ctrl_tb;
   localparam int CLK_P = 10;
   localparam int REG_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic in_token = 1'b0, pkt_ready = 1'b0, host_ack = 1'b0;
   logic host_timeout = 1'b0, fifo_underrun = 1'b0;
   logic hs_valid, hs_pid, fifo_flush, crc_corrupt;
   logic [1:0] hs_code;

   int n_chk = 0;
   int n_bad = 0;
   bit chk_en = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   usb_in_ep_ctrl #(.REG_W(REG_W), .CORRUPT_HOLD(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .in_token(in_token), .pkt_ready(pkt_ready),
      .host_ack(host_ack), .host_timeout(host_timeout),
      .fifo_underrun(fifo_underrun), .hs_valid(hs_valid), .hs_code(hs_code),
      .hs_pid(hs_pid), .fifo_flush(fifo_flush), .crc_corrupt(crc_corrupt)
   );

   // requirement-level model
   logic m_done, m_err, m_urun, m_sstl, m_force, m_tog, m_stall, m_busy, m_bad;
   logic e_hsv, e_pid, e_flush, e_crc;
   logic [1:0] e_hsc;
   logic t_acc, t_now, t_enter, t_leave, t_shs, t_send, t_fin, t_ue;

   function automatic logic [REG_W-1:0] exp_rdata();
      return {2'b00, m_tog, m_force, m_sstl, m_urun, m_err, m_done};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_done, m_err, m_urun, m_sstl, m_force, m_tog, m_stall, m_busy, m_bad} = '0;
         {e_hsv, e_pid, e_flush, e_crc} = '0;
         e_hsc = 2'b00;
      end else begin
         t_now   = m_force | m_stall;
         t_acc   = in_token & ~m_busy;
         t_enter = m_force & ~m_busy & ~m_stall;
         t_leave = m_stall & ~m_force & ~m_sstl;
         t_fin   = m_busy & (host_ack | host_timeout);
         t_ue    = m_busy & fifo_underrun;
         t_shs = 1'b0; t_send = 1'b0;
         e_hsv = t_acc; e_hsc = 2'b00; e_pid = 1'b0; e_flush = 1'b0; e_crc = 1'b0;
         if (t_acc) begin
            if (t_now) begin e_hsc = 2'b11; t_shs = 1'b1; end
            else if (pkt_ready && !m_done) begin e_hsc = 2'b01; e_pid = m_tog; t_send = 1'b1; end
            else e_hsc = 2'b10;
         end
         if (reg_we) begin
            if (reg_wdata[0]) begin m_done = 1'b0; m_err = 1'b0; m_urun = 1'b0; end
            if (reg_wdata[1]) m_err = 1'b0;
            if (reg_wdata[2]) m_urun = 1'b0;
            if (reg_wdata[3] && m_sstl && !(t_enter || t_shs)) begin m_sstl = 1'b0; e_flush = 1'b1; end
            m_force = reg_wdata[4];
         end
         if (t_ue) begin m_urun = 1'b1; m_bad = 1'b1; e_crc = 1'b1; end
         if (t_fin) begin
            m_done = 1'b1;
            if (host_timeout && !host_ack) m_err = 1'b1;
            if (host_ack && !m_bad) m_tog = ~m_tog;
            m_busy = 1'b0;
         end
         if (t_send) begin m_busy = 1'b1; m_bad = 1'b0; end
         if (t_enter || t_shs) m_sstl = 1'b1;
         if (t_enter) m_stall = 1'b1;
         if (t_leave) begin m_stall = 1'b0; m_tog = 1'b0; end
      end
   end

   always @(negedge clk) begin
      if (rst_n && chk_en) begin
         check("R4 R7 done",         32'(reg_rdata[0]), 32'(m_done));
         check("R5 R7 err",          32'(reg_rdata[1]), 32'(m_err));
         check("R6 R7 urun",         32'(reg_rdata[2]), 32'(m_urun));
         check("R8 R9 R10 sstl",     32'(reg_rdata[3]), 32'(m_sstl));
         check("R8 force",           32'(reg_rdata[4]), 32'(m_force));
         check("R4 R11 toggle",      32'(reg_rdata[5]), 32'(m_tog));
         check("R1 reserved",        32'(reg_rdata[7:6]), 32'(0));
         check("R2 R3 R12 hs_valid", 32'(hs_valid), 32'(e_hsv));
         if (e_hsv) check("R2 R3 R8 hs_code", 32'(hs_code), 32'(e_hsc));
         if (e_hsv && e_hsc == 2'b01) check("R2 pid", 32'(hs_pid), 32'(e_pid));
         check("R10 flush",          32'(fifo_flush), 32'(e_flush));
         check("R6 crc",             32'(crc_corrupt), 32'(e_crc));
      end
   end

   task automatic step(input logic tk, input logic rdy, input logic ak, input logic to,
                       input logic ur, input logic we, input logic [REG_W-1:0] wd);
      @(negedge clk);
      in_token = tk; pkt_ready = rdy; host_ack = ak; host_timeout = to;
      fifo_underrun = ur; reg_we = we; reg_wdata = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 rdata after reset", 32'(reg_rdata), 32'(0));
      check("R1 no handshake", 32'(hs_valid), 32'(0));
      chk_en = 1'b1;

      step(1, 1, 0, 0, 0, 0, '0);        // R2: DATA0
      idle(1);
      step(0, 1, 1, 0, 0, 0, '0);        // R4: ack flips toggle
      step(1, 1, 0, 0, 0, 0, '0);        // R3: done set -> NAK
      step(0, 1, 0, 0, 0, 1, 8'h01);
      step(1, 0, 0, 0, 0, 0, '0);        // R3: no data -> NAK
      step(1, 1, 0, 0, 0, 0, '0);        // R2: DATA1
      step(1, 1, 0, 0, 0, 0, '0);        // R12: token while busy
      step(0, 1, 0, 1, 0, 0, '0);        // R5: timeout
      step(0, 1, 0, 0, 0, 1, 8'h02);     // R7: clear err only
      step(0, 1, 0, 0, 0, 1, 8'h01);
      step(1, 1, 0, 0, 0, 0, '0);
      step(0, 1, 0, 0, 1, 0, '0);        // R6: underrun
      step(0, 1, 1, 0, 0, 0, '0);        // R6: ack, no flip
      step(0, 1, 0, 0, 0, 1, 8'h01);

      // R9: force during open transaction is deferred
      step(1, 1, 0, 0, 0, 0, '0);
      step(0, 1, 0, 0, 0, 1, 8'h10);
      idle(2);
      check("R9 sstl held off while busy", 32'(reg_rdata[3]), 32'(0));
      step(0, 1, 0, 1, 0, 0, '0);
      idle(2);
      check("R9 sstl after transaction end", 32'(reg_rdata[3]), 32'(1));
      step(0, 1, 0, 0, 0, 1, 8'h11);     // clear done, keep force
      step(1, 1, 0, 0, 0, 0, '0);        // R8: STALL
      step(0, 1, 0, 0, 0, 1, 8'h00);     // clear force
      step(1, 1, 0, 0, 0, 0, '0);        // R11: still stalled
      step(0, 1, 0, 0, 0, 1, 8'h08);     // R10: clear sstl -> flush
      idle(2);
      check("R11 toggle back to DATA0", 32'(reg_rdata[5]), 32'(0));
      step(1, 1, 0, 0, 0, 0, '0);        // R2: DATA0 after recovery
      step(0, 1, 1, 0, 0, 0, '0);
      step(0, 1, 0, 0, 0, 1, 8'h01);

      for (int i = 0; i < 4000; i++) begin
         logic [REG_W-1:0] wd;
         wd = 8'($urandom);
         wd[4] = ($urandom % 4) == 0;
         step(($urandom % 4) == 0, ($urandom % 3) != 0, ($urandom % 5) == 0,
              ($urandom % 9) == 0, ($urandom % 17) == 0, ($urandom % 11) == 0, wd);
      end
      idle(3);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule